// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits in a UART receive path, between the deserializer and the receive FIFO. Each completed character arrives with a one-cycle valid strobe and its framing and parity error flags. The block compares the character with a programmable special-character value and with the selected pair of software flow-control characters. It then decides whether the character goes into the FIFO. It also raises a sticky special-character flag and one-cycle Xon or Xoff received pulses.

The special-character value is the same register as the second Xoff character. Bit 0 of every compare is the first-received bit of the character. A 2-bit mode field selects which flow-control pair is compared: `2'b10` selects pair 1 and `2'b01` selects pair 2. `2'b00` and `2'b11` turn flow-control comparison off. A flow-control character of the selected pair is consumed and not stored. A special character is stored, unless it is also the Xoff of the selected pair. When detection is enabled, every character is compared, including characters that carry an error flag.

Top module: `rx_spchar_det`

## Requirements
- R1: After reset, `fifo_we_o`, `spec_flag_o`, `xoff_rx_o` and `xon_rx_o` are 0.
- R2: A character that matches no active compare is written one cycle after `rx_valid_i`. `fifo_we_o` is 1 for one cycle, and `fifo_data_o`, `fifo_ferr_o` and `fifo_perr_o` equal the inputs of the strobe cycle.
- R3: With `det_en_i`=0, a character equal to `xoff2_i` does not set `spec_flag_o`. In mode `2'b00` it is stored like any other character.
- R4: With `det_en_i`=1, a character equal to `xoff2_i` sets `spec_flag_o` one cycle after the strobe. In modes `2'b00` and `2'b10` it is also written to the FIFO.
- R5: `spec_flag_o` stays 1 until a cycle with `stat_rd_i`=1 clears it on the next edge. A new match in the same cycle as the read keeps the flag at 1.
- R6: In mode `2'b10`, a character equal to `xoff1_i` is not stored and pulses `xoff_rx_o` for one cycle. A character equal to `xon1_i` is not stored and pulses `xon_rx_o` for one cycle. Special detection on `xoff2_i` works unchanged.
- R7: In mode `2'b01`, a character equal to `xoff2_i` is not stored and pulses `xoff_rx_o`. If `det_en_i`=1 it also sets `spec_flag_o`. A character equal to `xon2_i` is not stored and pulses `xon_rx_o`.
- R8: In modes `2'b00` and `2'b11`, characters equal to `xon1_i`, `xoff1_i` or `xon2_i` are stored, and no Xon or Xoff pulse is raised.
- R9: A character with `rx_ferr_i` or `rx_perr_i` set is still compared. A matching errored character sets `spec_flag_o`, and its error flags travel with it into the FIFO.
- R10: With `rx_valid_i`=0, `fifo_we_o`, `xoff_rx_o` and `xon_rx_o` stay 0 on the next cycle and `spec_flag_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe for a completed character |
| rx_data_i | input | DW | Received character, bit 0 first received |
| rx_ferr_i | input | 1 | Framing error of the character |
| rx_perr_i | input | 1 | Parity error of the character |
| det_en_i | input | 1 | Special-character detect enable |
| fc_mode_i | input | 2 | Flow-control compare pair select |
| xon1_i | input | DW | Xon character of pair 1 |
| xoff1_i | input | DW | Xoff character of pair 1 |
| xon2_i | input | DW | Xon character of pair 2 |
| xoff2_i | input | DW | Xoff character of pair 2, also the special character |
| stat_rd_i | input | 1 | Host status read, clears the special flag |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DW | Character written to the FIFO |
| fifo_ferr_o | output | 1 | Framing error written with the character |
| fifo_perr_o | output | 1 | Parity error written with the character |
| spec_flag_o | output | 1 | Sticky special-character detected flag |
| xoff_rx_o | output | 1 | One-cycle Xoff received pulse |
| xon_rx_o | output | 1 | One-cycle Xon received pulse |

## Verification
Every result is registered once. The FIFO write, the Xon and Xoff pulses and the setting of the special flag all appear after the first rising edge that follows the strobe. A status read clears the flag after the first edge that follows it. The bench drives a strobe on a falling edge and drops it on the next falling edge. It checks the outputs at that falling edge, which is half a cycle after the register has loaded. It then checks again one cycle later, to confirm that the pulses and the write strobe lasted exactly one cycle while the flag stayed set.

// File: rtl/rscd_pkg.sv
package rscd_pkg;
  typedef enum logic [1:0] {
    FC_OFF   = 2'b00,
    FC_PAIR2 = 2'b01,
    FC_PAIR1 = 2'b10,
    FC_RSVD  = 2'b11
  } fc_mode_e;

  localparam int unsigned NREF = 4;
  typedef enum logic [1:0] {
    REF_XON1  = 2'd0,
    REF_XOFF1 = 2'd1,
    REF_XON2  = 2'd2,
    REF_XOFF2 = 2'd3
  } ref_idx_e;

  typedef struct packed {
    logic we;
    logic spec;
    logic xoff;
    logic xon;
  } rscd_dec_t;
endpackage

// File: rtl/rscd_cmp.sv
module rscd_cmp #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREF = 4
) (
  input  logic [DW-1:0]   data_i,
  input  logic [DW-1:0]   ref_i [NREF],
  output logic [NREF-1:0] hit_o
);
  for (genvar g = 0; g < NREF; g++) begin : g_cmp
    assign hit_o[g] = (data_i == ref_i[g]);
  end
endmodule

// File: rtl/rscd_route.sv
module rscd_route
  import rscd_pkg::*;
#(
  parameter int unsigned NREF = 4
) (
  input  logic            valid_i,
  input  logic            det_en_i,
  input  logic [1:0]      fc_mode_i,
  input  logic [NREF-1:0] hit_i,
  output rscd_dec_t       dec_o
);
  logic fc_on, hit_xoff, hit_xon;

  always_comb begin
    fc_on    = (fc_mode_i == FC_PAIR1) || (fc_mode_i == FC_PAIR2);
    hit_xoff = 1'b0;
    hit_xon  = 1'b0;
    if (fc_mode_i == FC_PAIR1) begin
      hit_xoff = hit_i[REF_XOFF1];
      hit_xon  = hit_i[REF_XON1];
    end else if (fc_mode_i == FC_PAIR2) begin
      hit_xoff = hit_i[REF_XOFF2];
      hit_xon  = hit_i[REF_XON2];
    end
    // Xoff takes precedence when both references hold the same value
    dec_o.xoff = valid_i && fc_on && hit_xoff;
    dec_o.xon  = valid_i && fc_on && hit_xon && !hit_xoff;
    dec_o.spec = valid_i && det_en_i && hit_i[REF_XOFF2];
    dec_o.we   = valid_i && !(fc_on && (hit_xoff || hit_xon));
  end
endmodule

// File: rtl/rscd_out.sv
module rscd_out
  import rscd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rscd_dec_t     dec_i,
  input  logic [DW-1:0] data_i,
  input  logic          ferr_i,
  input  logic          perr_i,
  input  logic          clr_i,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          perr_o,
  output logic          xoff_o,
  output logic          xon_o,
  output logic          flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      xoff_o <= 1'b0;
      xon_o  <= 1'b0;
    end else begin
      we_o   <= dec_i.we;
      xoff_o <= dec_i.xoff;
      xon_o  <= dec_i.xon;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
    end else if (dec_i.we) begin
      data_o <= data_i;
      ferr_o <= ferr_i;
      perr_o <= perr_i;
    end
  end

  // A new detection wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_o <= 1'b0;
    else if (dec_i.spec)  flag_o <= 1'b1;
    else if (clr_i)       flag_o <= 1'b0;
  end
endmodule

// File: rtl/rx_spchar_det.sv
module rx_spchar_det
  import rscd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_ferr_i,
  input  logic          rx_perr_i,
  input  logic          det_en_i,
  input  logic [1:0]    fc_mode_i,
  input  logic [DW-1:0] xon1_i,
  input  logic [DW-1:0] xoff1_i,
  input  logic [DW-1:0] xon2_i,
  input  logic [DW-1:0] xoff2_i,
  input  logic          stat_rd_i,
  output logic          fifo_we_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          fifo_ferr_o,
  output logic          fifo_perr_o,
  output logic          spec_flag_o,
  output logic          xoff_rx_o,
  output logic          xon_rx_o
);
  logic [DW-1:0]   refs [NREF];
  logic [NREF-1:0] hit;
  rscd_dec_t       dec;

  assign refs[REF_XON1]  = xon1_i;
  assign refs[REF_XOFF1] = xoff1_i;
  assign refs[REF_XON2]  = xon2_i;
  assign refs[REF_XOFF2] = xoff2_i;

  rscd_cmp #(.DW(DW), .NREF(NREF)) i_cmp (
    .data_i (rx_data_i),
    .ref_i  (refs),
    .hit_o  (hit)
  );

  rscd_route #(.NREF(NREF)) i_route (
    .valid_i   (rx_valid_i),
    .det_en_i  (det_en_i),
    .fc_mode_i (fc_mode_i),
    .hit_i     (hit),
    .dec_o     (dec)
  );

  rscd_out #(.DW(DW)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec),
    .data_i (rx_data_i),
    .ferr_i (rx_ferr_i),
    .perr_i (rx_perr_i),
    .clr_i  (stat_rd_i),
    .we_o   (fifo_we_o),
    .data_o (fifo_data_o),
    .ferr_o (fifo_ferr_o),
    .perr_o (fifo_perr_o),
    .xoff_o (xoff_rx_o),
    .xon_o  (xon_rx_o),
    .flag_o (spec_flag_o)
  );
endmodule

// File: rtl/rscd_chk.sv
module rscd_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic [DW-1:0] rx_data_i,
  input logic          rx_ferr_i,
  input logic          rx_perr_i,
  input logic          det_en_i,
  input logic [1:0]    fc_mode_i,
  input logic [DW-1:0] xon1_i,
  input logic [DW-1:0] xoff1_i,
  input logic [DW-1:0] xon2_i,
  input logic [DW-1:0] xoff2_i,
  input logic          stat_rd_i,
  input logic          fifo_we_o,
  input logic [DW-1:0] fifo_data_o,
  input logic          fifo_ferr_o,
  input logic          fifo_perr_o,
  input logic          spec_flag_o,
  input logic          xoff_rx_o,
  input logic          xon_rx_o
);
  assert_no_idle_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !fifo_we_o && !xoff_rx_o && !xon_rx_o);

  assert_flag_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && det_en_i && rx_data_i == xoff2_i) |=> spec_flag_o);

  assert_flag_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spec_flag_o && !(rx_valid_i && det_en_i)) |=> !spec_flag_o);

  assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !rx_valid_i) |=> !spec_flag_o);

  assert_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fc_mode_i == 2'b00) |=>
      fifo_we_o && fifo_data_o == $past(rx_data_i) &&
      fifo_ferr_o == $past(rx_ferr_i) && fifo_perr_o == $past(rx_perr_i));

  assert_pair2_xoff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fc_mode_i == 2'b01 && rx_data_i == xoff2_i) |=> xoff_rx_o && !fifo_we_o);

  assert_pair1_xoff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fc_mode_i == 2'b10 && rx_data_i == xoff1_i) |=> xoff_rx_o && !fifo_we_o);

  assert_fc_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_mode_i == 2'b00 || fc_mode_i == 2'b11) |=> !xoff_rx_o && !xon_rx_o);
endmodule

bind rx_spchar_det rscd_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_rx_spchar_det.sv
`timescale 1ns/1ps
module test_rx_spchar_det;
  localparam int DW = 8;
  localparam logic [DW-1:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h21, XOFF2 = 8'h23;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 0, rx_ferr_i = 0, rx_perr_i = 0, det_en_i = 0, stat_rd_i = 0;
  logic [DW-1:0] rx_data_i = '0;
  logic [1:0] fc_mode_i = 2'b00;
  logic fifo_we_o, fifo_ferr_o, fifo_perr_o, spec_flag_o, xoff_rx_o, xon_rx_o;
  logic [DW-1:0] fifo_data_o;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  rx_spchar_det #(.DW(DW)) i_rx_spchar_det (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_ferr_i, .rx_perr_i,
    .det_en_i, .fc_mode_i, .xon1_i(XON1), .xoff1_i(XOFF1), .xon2_i(XON2),
    .xoff2_i(XOFF2), .stat_rd_i, .fifo_we_o, .fifo_data_o, .fifo_ferr_o,
    .fifo_perr_o, .spec_flag_o, .xoff_rx_o, .xon_rx_o
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // strobe one character; returns at the negedge after the capturing posedge
  task automatic send(logic [DW-1:0] d, logic fe = 0, logic pe = 0, logic rd = 0);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = d; rx_ferr_i = fe; rx_perr_i = pe; stat_rd_i = rd;
    @(negedge clk_i);
    rx_valid_i = 0; rx_ferr_i = 0; rx_perr_i = 0; stat_rd_i = 0;
  endtask

  task automatic expect_out(string req, logic we, logic [DW-1:0] d, logic xo, logic xn, logic fl);
    chk(req, "we", fifo_we_o, we);
    if (we) chk(req, "data", fifo_data_o, d);
    chk(req, "xoff", xoff_rx_o, xo);
    chk(req, "xon", xon_rx_o, xn);
    chk(req, "flag", spec_flag_o, fl);
  endtask

  task automatic clear_flag();
    @(negedge clk_i); stat_rd_i = 1;
    @(negedge clk_i); stat_rd_i = 0;
  endtask

  task automatic t_reset();
    expect_out("R1", 0, '0, 0, 0, 0);
  endtask

  task automatic t_passthru();
    det_en_i = 1; fc_mode_i = 2'b00;
    send(8'h5a);
    expect_out("R2", 1, 8'h5a, 0, 0, 0);
    chk("R2", "ferr", fifo_ferr_o, 0);
    @(negedge clk_i);
    chk("R2", "we one cycle", fifo_we_o, 0);
    send(8'ha5, 1, 1);
    expect_out("R2", 1, 8'ha5, 0, 0, 0);
    chk("R2", "ferr", fifo_ferr_o, 1);
    chk("R2", "perr", fifo_perr_o, 1);
  endtask

  task automatic t_det_off();
    det_en_i = 0; fc_mode_i = 2'b00;
    send(XOFF2);
    expect_out("R3", 1, XOFF2, 0, 0, 0);
  endtask

  task automatic t_det_on();
    det_en_i = 1; fc_mode_i = 2'b00;
    send(XOFF2);
    expect_out("R4", 1, XOFF2, 0, 0, 1);
    @(negedge clk_i);
    chk("R5", "flag sticky", spec_flag_o, 1);
    chk("R4", "we one cycle", fifo_we_o, 0);
    clear_flag();
    chk("R5", "flag cleared", spec_flag_o, 0);
    send(XOFF2, 0, 0, 1);
    chk("R5", "set beats clear", spec_flag_o, 1);
    clear_flag();
    chk("R5", "flag cleared again", spec_flag_o, 0);
  endtask

  task automatic t_pair1();
    det_en_i = 1; fc_mode_i = 2'b10;
    send(XOFF1);
    expect_out("R6", 0, '0, 1, 0, 0);
    @(negedge clk_i);
    chk("R6", "xoff one cycle", xoff_rx_o, 0);
    send(XON1);
    expect_out("R6", 0, '0, 0, 1, 0);
    send(XOFF2);
    expect_out("R6", 1, XOFF2, 0, 0, 1);
    clear_flag();
  endtask

  task automatic t_pair2();
    det_en_i = 1; fc_mode_i = 2'b01;
    send(XOFF2);
    expect_out("R7", 0, '0, 1, 0, 1);
    clear_flag();
    send(XON2);
    expect_out("R7", 0, '0, 0, 1, 0);
    send(XOFF1);
    expect_out("R7", 1, XOFF1, 0, 0, 0);
    det_en_i = 0;
    send(XOFF2);
    expect_out("R7", 0, '0, 1, 0, 0);
  endtask

  task automatic t_fc_off();
    det_en_i = 0;
    for (int m = 0; m < 4; m += 3) begin
      fc_mode_i = 2'(m);
      send(XOFF1);
      expect_out("R8", 1, XOFF1, 0, 0, 0);
      send(XON1);
      expect_out("R8", 1, XON1, 0, 0, 0);
      send(XON2);
      expect_out("R8", 1, XON2, 0, 0, 0);
    end
  endtask

  task automatic t_err();
    det_en_i = 1; fc_mode_i = 2'b00;
    send(XOFF2, 1, 0);
    expect_out("R9", 1, XOFF2, 0, 0, 1);
    chk("R9", "ferr", fifo_ferr_o, 1);
    chk("R9", "perr", fifo_perr_o, 0);
    clear_flag();
    send(XOFF2, 0, 1);
    chk("R9", "flag", spec_flag_o, 1);
    chk("R9", "perr", fifo_perr_o, 1);
    clear_flag();
  endtask

  task automatic t_idle();
    det_en_i = 1; fc_mode_i = 2'b01;
    @(negedge clk_i); rx_data_i = XOFF2;
    @(negedge clk_i);
    expect_out("R10", 0, '0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #35;
    t_reset();
    rst_ni = 1;
    t_passthru();
    t_det_off();
    t_det_on();
    t_pair1();
    t_pair2();
    t_fc_off();
    t_err();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule